// File: doc/BRIEF.md
# Stream-to-Flit Packetizer

This block sits between a user module that emits wide words on a valid/ready stream and one port of an on-chip network router. Each accepted word is cut into a fixed burst of `TDM` narrow flits, sent lowest slice first. Every flit carries a destination router number and a virtual-channel number. Both are sampled from static configuration inputs when the word is accepted.

The router gives back one ready bit per virtual channel. A flit moves only while the ready bit of the channel it names is high; the ready bits of the other channels do not matter. While a burst is in progress the block accepts no new word, so the upstream stream is stalled until the tail flit has gone out. With the default sizes (150-bit flits, a TDM factor of 4, 16 routers, 4 channels) a 600-bit word becomes four flits, with a 4-bit destination and a 2-bit channel field. The module clock and the router clock are treated as one clock here.

Top module: `stream_noc_packetizer`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 exactly when no burst is in progress. A word is accepted at a rising edge where `in_valid` and `in_ready` are both 1.
- R3: Flit number k (k = 0 to TDM-1) of a burst carries word bits [k*FLIT_W +: FLIT_W]. Flits leave in increasing k.
- R4: `out_head` is 1 only on flit 0 and `out_tail` is 1 only on flit TDM-1. When TDM is 1, both are 1 on the single flit.
- R5: `out_dest` and `out_vc` hold the `cfg_dest` and `cfg_vc` values present at acceptance for the whole burst. Later changes to the configuration inputs do not affect them.
- R6: A flit is transferred at a rising edge where `out_valid` is 1 and bit `out_vc` of `vc_ready` is 1. The other bits of `vc_ready` have no effect.
- R7: While the selected ready bit is 0, the current flit's data, head, tail, destination and channel stay unchanged.
- R8: `out_valid` rises in the cycle after acceptance, showing flit 0.
- R9: After the tail flit is transferred, the next cycle has `out_valid` at 0 and `in_ready` at 1.
- R10: `in_valid` and `in_data` are ignored while a burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dest | input | DEST_W | Destination router for the next word |
| cfg_vc | input | VC_W | Virtual channel for the next word |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Upstream word ready |
| in_data | input | FLIT_W*TDM | Upstream wide word |
| out_valid | output | 1 | Flit valid |
| out_head | output | 1 | First flit of a burst |
| out_tail | output | 1 | Last flit of a burst |
| out_dest | output | DEST_W | Destination router of the flit |
| out_vc | output | VC_W | Virtual channel of the flit |
| out_data | output | FLIT_W | Flit payload |
| vc_ready | input | VCS | Per-channel ready from the router |

## Verification
After a word is accepted, flit 0 appears one cycle later. Each later flit appears one cycle after the transfer of the one before it. `in_ready` returns one cycle after the tail transfer. The bench drives inputs on the falling edge and checks every flit, stalled or not, on the falling edge that follows the rising edge that produced it. It therefore compares each result in exactly the cycle the register chain makes it due. Stall lengths, the stall position, the destination and the channel are swept over all 64 destination/channel pairs. A second instance with TDM of 1 covers the single-flit case.

// File: rtl/pkt_pkg.sv
package pkt_pkg;

    localparam int unsigned DEF_FLIT_W  = 150;
    localparam int unsigned DEF_TDM     = 4;
    localparam int unsigned DEF_ROUTERS = 16;
    localparam int unsigned DEF_VCS     = 4;

    typedef enum logic {
        SER_IDLE = 1'b0,
        SER_SEND = 1'b1
    } ser_state_e;

    // Width of an index that selects one of n items (at least one bit).
    function automatic int unsigned idx_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pkt_word_hold.sv
module pkt_word_hold #(
    parameter int unsigned WORD_W = 600,
    parameter int unsigned DEST_W = 4,
    parameter int unsigned VC_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic [DEST_W-1:0] dest_in,
    input  logic [VC_W-1:0]   vc_in,
    output logic [WORD_W-1:0] word_q,
    output logic [DEST_W-1:0] dest_q,
    output logic [VC_W-1:0]   vc_q
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [DEST_W-1:0] dest;
        logic [VC_W-1:0]   vc;
    } held_t;

    held_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (load) begin
            held <= '{word: word_in, dest: dest_in, vc: vc_in};
        end
    end

    assign word_q = held.word;
    assign dest_q = held.dest;
    assign vc_q   = held.vc;

endmodule

// File: rtl/pkt_flit_seq.sv
module pkt_flit_seq
    import pkt_pkg::*;
#(
    parameter int unsigned TDM   = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             advance,
    output logic             busy,
    output logic [IDX_W-1:0] idx,
    output logic             is_head,
    output logic             is_tail
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TDM - 1);

    ser_state_e       state;
    logic [IDX_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SER_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                SER_IDLE: begin
                    if (start) begin
                        state <= SER_SEND;
                        cnt   <= '0;
                    end
                end
                SER_SEND: begin
                    if (advance) begin
                        if (cnt == LAST_IDX) begin
                            state <= SER_IDLE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= SER_IDLE;
            endcase
        end
    end

    assign busy    = (state == SER_SEND);
    assign idx     = cnt;
    assign is_head = (cnt == '0);
    assign is_tail = (cnt == LAST_IDX);

endmodule

// File: rtl/pkt_flit_mux.sv
module pkt_flit_mux #(
    parameter int unsigned FLIT_W = 150,
    parameter int unsigned TDM    = 4,
    parameter int unsigned IDX_W  = 2
) (
    input  logic [FLIT_W*TDM-1:0] word,
    input  logic [IDX_W-1:0]      idx,
    output logic [FLIT_W-1:0]     flit
);

    generate
        if (TDM == 1) begin : g_single
            assign flit = word;
            logic unused_idx;
            assign unused_idx = ^idx;
        end else begin : g_multi
            logic [FLIT_W-1:0] slices [TDM];
            for (genvar k = 0; k < TDM; k++) begin : g_slice
                assign slices[k] = word[k*FLIT_W +: FLIT_W];
            end
            assign flit = slices[idx];
        end
    endgenerate

endmodule

// File: rtl/stream_noc_packetizer.sv
module stream_noc_packetizer
    import pkt_pkg::*;
#(
    parameter  int unsigned FLIT_W  = DEF_FLIT_W,
    parameter  int unsigned TDM     = DEF_TDM,
    parameter  int unsigned ROUTERS = DEF_ROUTERS,
    parameter  int unsigned VCS     = DEF_VCS,
    localparam int unsigned WORD_W  = FLIT_W * TDM,
    localparam int unsigned DEST_W  = idx_width(ROUTERS),
    localparam int unsigned VC_W    = idx_width(VCS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DEST_W-1:0] cfg_dest,
    input  logic [VC_W-1:0]   cfg_vc,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_head,
    output logic              out_tail,
    output logic [DEST_W-1:0] out_dest,
    output logic [VC_W-1:0]   out_vc,
    output logic [FLIT_W-1:0] out_data,
    input  logic [VCS-1:0]    vc_ready
);

    localparam int unsigned IDX_W = idx_width(TDM);

    logic              busy;
    logic              accept;
    logic              advance;
    logic              sel_ready;
    logic [IDX_W-1:0]  idx;
    logic              is_head;
    logic              is_tail;
    logic [WORD_W-1:0] word_q;

    assign in_ready  = !busy;
    assign accept    = in_valid && !busy;
    assign sel_ready = vc_ready[out_vc];
    assign advance   = busy && sel_ready;

    pkt_word_hold #(
        .WORD_W (WORD_W),
        .DEST_W (DEST_W),
        .VC_W   (VC_W)
    ) hold_i (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .word_in (in_data),
        .dest_in (cfg_dest),
        .vc_in   (cfg_vc),
        .word_q  (word_q),
        .dest_q  (out_dest),
        .vc_q    (out_vc)
    );

    pkt_flit_seq #(
        .TDM   (TDM),
        .IDX_W (IDX_W)
    ) seq_i (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .advance (advance),
        .busy    (busy),
        .idx     (idx),
        .is_head (is_head),
        .is_tail (is_tail)
    );

    pkt_flit_mux #(
        .FLIT_W (FLIT_W),
        .TDM    (TDM),
        .IDX_W  (IDX_W)
    ) mux_i (
        .word (word_q),
        .idx  (idx),
        .flit (out_data)
    );

    assign out_valid = busy;
    assign out_head  = busy && is_head;
    assign out_tail  = busy && is_tail;

endmodule

// File: rtl/pkt_checker.sv
module pkt_checker #(
    parameter int unsigned FLIT_W = 150,
    parameter int unsigned DEST_W = 4,
    parameter int unsigned VC_W   = 2,
    parameter int unsigned VCS    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_head,
    input logic              out_tail,
    input logic [DEST_W-1:0] out_dest,
    input logic [VC_W-1:0]   out_vc,
    input logic [FLIT_W-1:0] out_data,
    input logic [VCS-1:0]    vc_ready
);

    logic sel_rdy;
    assign sel_rdy = vc_ready[out_vc];

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    // R8
    accept_head_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && out_head));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !sel_rdy) |=> (out_valid && $stable(out_data) && $stable(out_head)
                                     && $stable(out_tail) && $stable(out_dest) && $stable(out_vc)));

    // R5
    cfg_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> ($stable(out_dest) && $stable(out_vc)));

    // R9
    tail_release_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sel_rdy && out_tail) |=> (in_ready && !out_valid));

    // R4
    mid_not_head_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sel_rdy && !out_tail) |=> (out_valid && !out_head));

    // R2
    busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

endmodule

bind stream_noc_packetizer pkt_checker #(
    .FLIT_W (FLIT_W),
    .DEST_W (DEST_W),
    .VC_W   (VC_W),
    .VCS    (VCS)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_head  (out_head),
    .out_tail  (out_tail),
    .out_dest  (out_dest),
    .out_vc    (out_vc),
    .out_data  (out_data),
    .vc_ready  (vc_ready)
);

// File: tb/stream_noc_packetizer_tb_top.sv
module stream_noc_packetizer_tb_top;

    localparam int FW  = 8;
    localparam int T   = 4;
    localparam int WW  = FW * T;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    // main instance, TDM = 4
    logic [3:0]    cfg_dest = '0;
    logic [1:0]    cfg_vc   = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [WW-1:0] in_data  = '0;
    logic          out_valid, out_head, out_tail;
    logic [3:0]    out_dest;
    logic [1:0]    out_vc;
    logic [FW-1:0] out_data;
    logic [3:0]    vc_ready = '0;

    stream_noc_packetizer #(.FLIT_W(FW), .TDM(T), .ROUTERS(16), .VCS(4)) dut_i (
        .clk(clk), .rst(rst), .cfg_dest(cfg_dest), .cfg_vc(cfg_vc),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_head(out_head), .out_tail(out_tail),
        .out_dest(out_dest), .out_vc(out_vc), .out_data(out_data),
        .vc_ready(vc_ready));

    // single-flit instance, TDM = 1
    logic [3:0]    b_dest = '0;
    logic [1:0]    b_vc   = '0;
    logic          b_in_valid = 1'b0;
    logic          b_in_ready;
    logic [FW-1:0] b_in_data = '0;
    logic          b_valid, b_head, b_tail;
    logic [3:0]    b_odest;
    logic [1:0]    b_ovc;
    logic [FW-1:0] b_odata;
    logic [3:0]    b_vc_ready = 4'hF;

    stream_noc_packetizer #(.FLIT_W(FW), .TDM(1), .ROUTERS(16), .VCS(4)) dut_t1_i (
        .clk(clk), .rst(rst), .cfg_dest(b_dest), .cfg_vc(b_vc),
        .in_valid(b_in_valid), .in_ready(b_in_ready), .in_data(b_in_data),
        .out_valid(b_valid), .out_head(b_head), .out_tail(b_tail),
        .out_dest(b_odest), .out_vc(b_ovc), .out_data(b_odata),
        .vc_ready(b_vc_ready));

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            fails++;
            $display("FAIL R9 watchdog expired: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check_flit(input logic [WW-1:0] w, input int k,
                              input logic [3:0] d, input logic [1:0] v);
        chk("R3", "out_valid", 64'(out_valid), 64'd1);
        chk("R3", "data", 64'(out_data), 64'(w[k*FW +: FW]));
        chk("R4", "head", 64'(out_head), 64'(k == 0));
        chk("R4", "tail", 64'(out_tail), 64'(k == T-1));
        chk("R5", "dest", 64'(out_dest), 64'(d));
        chk("R5", "vc", 64'(out_vc), 64'(v));
        chk("R2", "in_ready busy", 64'(in_ready), 64'd0);
    endtask

    task automatic send_word(input int i);
        logic [WW-1:0] w;
        logic [3:0] d;
        logic [1:0] v;
        int stall_at;
        int stall_len;
        w = WW'(i * 32'h9E3779B1) ^ WW'(32'h5A0F_C3A5 + i);
        d = 4'(i);
        v = 2'(i >> 4);
        stall_at  = i % T;
        stall_len = i % 3;
        // negedge: present word
        chk("R2", "in_ready idle", 64'(in_ready), 64'd1);
        in_valid = 1'b1;
        in_data  = w;
        cfg_dest = d;
        cfg_vc   = v;
        vc_ready = 4'h0;
        @(posedge clk);
        @(negedge clk);
        // R10 / R5: disturb inputs during the burst
        in_valid = 1'b1;
        in_data  = ~w;
        cfg_dest = ~d;
        cfg_vc   = ~v;
        for (int k = 0; k < T; k++) begin
            if (k == stall_at) begin
                for (int s = 0; s < stall_len; s++) begin
                    // R6: every other channel ready, the selected one not
                    vc_ready = ~(4'b1 << v);
                    check_flit(w, k, d, v);
                    @(posedge clk);
                    @(negedge clk);
                    // R7: held across the stall
                    check_flit(w, k, d, v);
                end
            end
            vc_ready = 4'b1 << v;
            check_flit(w, k, d, v);
            @(posedge clk);
            @(negedge clk);
        end
        vc_ready = 4'h0;
        // R9: one cycle after the tail transfer
        chk("R9", "out_valid after tail", 64'(out_valid), 64'd0);
        chk("R9", "in_ready after tail", 64'(in_ready), 64'd1);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1", "out_valid in reset", 64'(out_valid), 64'd0);
        chk("R1", "in_ready in reset", 64'(in_ready), 64'd1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "out_valid after reset", 64'(out_valid), 64'd0);
        chk("R1", "in_ready after reset", 64'(in_ready), 64'd1);

        // R6: no acceptance pending, no spurious output while idle
        @(negedge clk);
        chk("R8", "idle out_valid", 64'(out_valid), 64'd0);

        for (int i = 0; i < 64; i++) begin
            send_word(i);
        end

        // single-flit instance: head and tail together
        for (int i = 0; i < 16; i++) begin
            logic [FW-1:0] bw;
            bw = FW'(i * 37 + 11);
            b_in_valid = 1'b1;
            b_in_data  = bw;
            b_dest     = 4'(15 - i);
            b_vc       = 2'(i);
            @(posedge clk);
            @(negedge clk);
            b_in_valid = 1'b0;
            b_in_data  = ~bw;
            chk("R8", "t1 valid", 64'(b_valid), 64'd1);
            chk("R4", "t1 head", 64'(b_head), 64'd1);
            chk("R4", "t1 tail", 64'(b_tail), 64'd1);
            chk("R3", "t1 data", 64'(b_odata), 64'(bw));
            chk("R5", "t1 dest", 64'(b_odest), 64'(15 - i));
            @(posedge clk);
            @(negedge clk);
            chk("R9", "t1 released", 64'(b_in_ready), 64'd1);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule